// File: doc/BRIEF.md
# Encoded Step Sequencer with Illegal-State Detection

This block walks through a fixed chain of N steps, moving one step forward on each cycle in which the advance strobe is high. Two parameters shape it. One chooses what follows the final step: it either returns to the first step or stays on the final step until a clear. The other chooses how the state register holds the step: a plain binary count, a reflected Gray code, or a one-hot vector.

Whatever the encoding, the block decodes the register into a binary step index and a flag for the final step. It watches the register for codes that belong to no step. When it sees one, it raises an error output in that same cycle and returns to the first step on the next edge. A test-only load port writes any raw code into the register, so that faults can be provoked from the bench.

Top module: `step_seq`

## Requirements
- R1: Reset and a synchronous clear both put the register at the first step, which reads as index 0 with the error low. When clear and advance are high together, clear wins.
- R2: When advance is high on a legal state that is not the last step, the index rises by one at the next edge. Without advance, clear or load, the index holds.
- R3: In cyclic mode (WRAP=1), advancing from index N-1 gives index 0.
- R4: In sink mode (WRAP=0), advancing from index N-1 leaves the index at N-1.
- R5: last_o is high exactly when the index is N-1 and the state is legal.
- R6: Binary encoding uses code k for step k. Loading code k with k<N reads back as index k.
- R7: Gray encoding with W=clog2(N) bits and H=N/2 stores step k as gray(k) when k<H and as gray(k+2^W-N) otherwise, where gray(v)=v^(v>>1). Any two neighbouring steps, the wrap included, differ in one bit.
- R8: One-hot encoding stores step k as bit k alone. Any code with zero bits set, or with more than one bit set, is illegal.
- R9: In binary and Gray, every code outside the N assigned codes is illegal (for N=6: binary 6 and 7, Gray 3'b010 and 3'b110).
- R10: While the state is illegal, err_o is high in that same cycle and the index reads 0. At the next edge the register returns to the first step even if advance is high.
- R11: A one-hot fault that clears the hot bit and sets another bit gives a legal code. That fault is not flagged: err_o stays low and the index shows the new bit position.
- R12: When ld_en is high, ld_code is written into the register at the next edge. This load has priority over clear, advance and recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear to the first step |
| adv | input | 1 | Advance strobe |
| ld_en | input | 1 | Test-only raw register load enable |
| ld_code | input | SW | Raw code to load (SW = N for one-hot, clog2(N) otherwise) |
| step_idx | output | IW | Decoded binary step index, 0..N-1 |
| last_o | output | 1 | High while on the final step |
| err_o | output | 1 | High while the register holds an illegal code |

## Verification
Recovery from an illegal state can fall in the same cycle as an advance strobe. To provoke this, the bench loads a bad code into one instance and raises advance on the very next cycle. It then expects that instance at index 0, while its sibling instances, which are fed the same strobe, move forward by one. A second clash comes from loading a code while clear is high. The loaded instance must show the loaded step and the others must show index 0.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int ENC_BIN  = 0;
  localparam int ENC_GRAY = 1;
  localparam int ENC_HOT  = 2;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/seq_next.sv
module seq_next #(
  parameter int N    = 6,
  parameter int WRAP = 1,
  parameter int IW   = 3
) (
  input  logic [IW-1:0] cur,
  output logic [IW-1:0] nxt
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  generate
    if (WRAP != 0) begin : g_cyc
      assign nxt = (cur == LAST) ? '0 : cur + 1'b1;
    end else begin : g_sink
      assign nxt = (cur == LAST) ? LAST : cur + 1'b1;
    end
  endgenerate
endmodule

// File: rtl/seq_enc.sv
module seq_enc
  import seq_pkg::*;
#(
  parameter int N   = 6,
  parameter int ENC = ENC_BIN,
  parameter int IW  = 3,
  parameter int SW  = 3
) (
  input  logic [IW-1:0] idx,
  output logic [SW-1:0] code
);
  localparam int H   = N / 2;
  localparam int GAP = (1 << IW) - N;

  generate
    if (ENC == ENC_HOT) begin : g_hot
      always_comb begin
        code = '0;
        for (int i = 0; i < SW; i++) code[i] = (32'(idx) == i);
      end
    end else if (ENC == ENC_GRAY) begin : g_gray
      logic [31:0] lin;
      logic [31:0] gv;
      always_comb begin
        lin  = (32'(idx) < H) ? 32'(idx) : 32'(idx) + 32'(GAP);
        gv   = to_gray(lin);
        code = gv[SW-1:0];
      end
    end else begin : g_bin
      assign code = SW'(idx);
    end
  endgenerate
endmodule

// File: rtl/seq_dec.sv
module seq_dec
  import seq_pkg::*;
#(
  parameter int N   = 6,
  parameter int ENC = ENC_BIN,
  parameter int IW  = 3,
  parameter int SW  = 3
) (
  input  logic [SW-1:0] code,
  output logic [IW-1:0] idx,
  output logic          legal
);
  localparam int H   = N / 2;
  localparam int GAP = (1 << IW) - N;
  localparam int HI  = (1 << IW) - (N - H);

  generate
    if (ENC == ENC_HOT) begin : g_hot
      logic [IW-1:0] acc;
      always_comb begin
        acc = '0;
        for (int i = 0; i < SW; i++)
          if (code[i]) acc = acc | IW'(i);
        legal = $onehot(code);
        idx   = legal ? acc : '0;
      end
    end else if (ENC == ENC_GRAY) begin : g_gray
      logic [31:0] lin;
      always_comb begin
        lin = from_gray(32'(code));
        if (lin < 32'(H)) begin
          legal = 1'b1;
          idx   = IW'(lin);
        end else if (lin >= 32'(HI)) begin
          legal = 1'b1;
          idx   = IW'(lin - 32'(GAP));
        end else begin
          legal = 1'b0;
          idx   = '0;
        end
      end
    end else begin : g_bin
      always_comb begin
        legal = (32'(code) < N);
        idx   = legal ? IW'(code) : '0;
      end
    end
  endgenerate
endmodule

// File: rtl/step_seq.sv
module step_seq
  import seq_pkg::*;
#(
  parameter int N_STEPS  = 6,
  parameter int ENCODING = ENC_BIN,
  parameter int WRAP     = 1,
  localparam int IW      = (N_STEPS > 2) ? $clog2(N_STEPS) : 1,
  localparam int SW      = (ENCODING == ENC_HOT) ? N_STEPS : IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_code,
  output logic [IW-1:0] step_idx,
  output logic          last_o,
  output logic          err_o
);
  logic [SW-1:0] state_q;
  logic [SW-1:0] first_code;
  logic [SW-1:0] next_code;
  logic [IW-1:0] cur_idx;
  logic [IW-1:0] nxt_idx;
  logic          legal;

  seq_dec #(.N(N_STEPS), .ENC(ENCODING), .IW(IW), .SW(SW)) dec_i (
    .code (state_q),
    .idx  (cur_idx),
    .legal(legal)
  );

  seq_next #(.N(N_STEPS), .WRAP(WRAP), .IW(IW)) nxt_i (
    .cur(cur_idx),
    .nxt(nxt_idx)
  );

  seq_enc #(.N(N_STEPS), .ENC(ENCODING), .IW(IW), .SW(SW)) enc_next_i (
    .idx (nxt_idx),
    .code(next_code)
  );

  seq_enc #(.N(N_STEPS), .ENC(ENCODING), .IW(IW), .SW(SW)) enc_first_i (
    .idx ('0),
    .code(first_code)
  );

  always_ff @(posedge clk) begin
    if (rst)                state_q <= first_code;
    else if (ld_en)         state_q <= ld_code;
    else if (clr || !legal) state_q <= first_code;
    else if (adv)           state_q <= next_code;
  end

  assign step_idx = cur_idx;
  assign last_o   = legal && (cur_idx == IW'(N_STEPS - 1));
  assign err_o    = !legal;
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk #(
  parameter int N    = 6,
  parameter int ENC  = 0,
  parameter int WRAP = 1,
  parameter int IW   = 3,
  parameter int SW   = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic          adv,
  input logic          ld_en,
  input logic [SW-1:0] ld_code,
  input logic [SW-1:0] state_q,
  input logic [IW-1:0] step_idx,
  input logic          last_o,
  input logic          err_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  a_r1_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !ld_en) |=> (step_idx == '0 && !err_o));

  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && !ld_en && !err_o && !last_o) |=> (step_idx == IW'($past(step_idx) + 1'b1)));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr && !ld_en && !err_o) |=> $stable(step_idx));

  a_r5_last: assert property (@(posedge clk) disable iff (rst)
    last_o |-> (step_idx == LAST && !err_o));

  a_r10_recover: assert property (@(posedge clk) disable iff (rst)
    (err_o && !ld_en) |=> (!err_o && step_idx == '0));

  a_r12_load: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (state_q == $past(ld_code)));

  generate
    if (WRAP != 0) begin : g_cyc
      a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && last_o && !clr && !ld_en) |=> (step_idx == '0));
    end else begin : g_sink
      a_r4_sink: assert property (@(posedge clk) disable iff (rst)
        (adv && last_o && !clr && !ld_en) |=> last_o);
    end
    if (ENC == 1) begin : g_gray
      a_r7_one_bit: assert property (@(posedge clk) disable iff (rst)
        (adv && !err_o && !clr && !ld_en && !(WRAP == 0 && last_o))
          |=> ($countones(state_q ^ $past(state_q)) == 1));
    end
  endgenerate
endmodule

bind step_seq step_seq_chk #(
  .N(N_STEPS), .ENC(ENCODING), .WRAP(WRAP), .IW(IW), .SW(SW)
) chk_i (
  .clk(clk), .rst(rst), .clr(clr), .adv(adv), .ld_en(ld_en),
  .ld_code(ld_code), .state_q(state_q), .step_idx(step_idx),
  .last_o(last_o), .err_o(err_o)
);

// File: tb/step_seq_tb_top.sv
`timescale 1ns/1ps
module step_seq_tb_top;
  logic clk = 0;
  logic rst = 1, clr = 0, adv = 0;
  logic [2:0] ld_en = '0;
  logic [2:0] ld_b = '0, ld_g = '0;
  logic [4:0] ld_h = '0;
  logic [2:0] idx_b, idx_g, idx_h;
  logic last_b, last_g, last_h, err_b, err_g, err_h;

  always #5 clk = ~clk;

  step_seq #(.N_STEPS(6), .ENCODING(0), .WRAP(1)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv), .ld_en(ld_en[0]), .ld_code(ld_b),
    .step_idx(idx_b), .last_o(last_b), .err_o(err_b));
  step_seq #(.N_STEPS(6), .ENCODING(1), .WRAP(1)) dut_gray_i (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv), .ld_en(ld_en[1]), .ld_code(ld_g),
    .step_idx(idx_g), .last_o(last_g), .err_o(err_g));
  step_seq #(.N_STEPS(5), .ENCODING(2), .WRAP(0)) dut_hot_i (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv), .ld_en(ld_en[2]), .ld_code(ld_h),
    .step_idx(idx_h), .last_o(last_h), .err_o(err_h));

  typedef struct { int d; int idx; bit last; bit err; string req; } exp_t;
  exp_t q[$];
  int errors = 0, checks = 0;
  int m[3] = '{0, 0, 0};
  bit bad[3] = '{0, 0, 0};
  int nn[3] = '{6, 6, 5};
  bit cy[3] = '{1, 1, 0};
  bit done = 0;

  function automatic int gcode(input int k);
    int v;
    v = (k < 3) ? k : k + 2;
    return v ^ (v >> 1);
  endfunction

  // monitor: pop expectations and compare away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      int ai; bit al, ae;
      e = q.pop_front();
      case (e.d)
        0: begin ai = int'(idx_b); al = last_b; ae = err_b; end
        1: begin ai = int'(idx_g); al = last_g; ae = err_g; end
        default: begin ai = int'(idx_h); al = last_h; ae = err_h; end
      endcase
      checks++;
      if (ai != e.idx || al != e.last || ae != e.err) begin
        errors++;
        $display("FAIL %s dut%0d: idx/last/err actual %0d/%0b/%0b expected %0d/%0b/%0b",
                 e.req, e.d, ai, al, ae, e.idx, e.last, e.err);
      end
    end
  end

  task automatic push_all(input int d, input bit legal, input string req);
    for (int k = 0; k < 3; k++) begin
      exp_t e;
      e.d = k; e.idx = m[k]; e.req = req;
      e.err  = (k == d) && !legal;
      e.last = !e.err && (m[k] == nn[k] - 1);
      q.push_back(e);
    end
  endtask

  task automatic step(input bit a, input bit c, input int d, input int code,
                      input bit legal, input int eidx, input string req);
    adv = a; clr = c; ld_en = '0;
    if (d >= 0) begin
      ld_en[d] = 1'b1;
      ld_b = 3'(code); ld_g = 3'(code); ld_h = 5'(code);
    end
    @(posedge clk); #1;
    adv = 0; clr = 0; ld_en = '0;
    for (int k = 0; k < 3; k++) begin
      if (k == d) begin
        if (legal) m[k] = eidx; else begin m[k] = 0; bad[k] = 1; end
      end else if (bad[k]) begin
        m[k] = 0; bad[k] = 0;
      end else if (c) m[k] = 0;
      else if (a) m[k] = (m[k] == nn[k] - 1) ? (cy[k] ? 0 : m[k]) : m[k] + 1;
    end
    push_all(d, legal, req);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1; push_all(-1, 1, "R1 reset");
    rst = 0;
    for (int i = 0; i < 7; i++) step(1, 0, -1, 0, 1, 0, "R2 R3 R4 R5 advance");
    step(0, 0, -1, 0, 1, 0, "R2 hold");
    step(1, 0, -1, 0, 1, 0, "R2 advance");
    step(1, 1, -1, 0, 1, 0, "R1 clear over advance");
    for (int k = 0; k < 6; k++) step(0, 0, 1, gcode(k), 1, k, "R7 gray map");
    step(0, 0, 1, 3'b010, 0, 0, "R9 gray unused");
    step(1, 0, -1, 0, 1, 0, "R10 recover with advance");
    step(0, 0, 1, 3'b110, 0, 0, "R9 gray unused");
    step(1, 0, -1, 0, 1, 0, "R10 recover");
    for (int k = 0; k < 6; k++) step(0, 0, 0, k, 1, k, "R6 binary map");
    step(0, 0, 0, 6, 0, 0, "R9 binary unused");
    step(1, 0, -1, 0, 1, 0, "R10 recover");
    step(0, 0, 0, 7, 0, 0, "R9 binary unused");
    step(0, 0, -1, 0, 1, 0, "R10 recover no advance");
    for (int k = 0; k < 5; k++) step(0, 0, 2, 1 << k, 1, k, "R8 onehot map");
    step(0, 0, 2, 0, 0, 0, "R8 onehot zero");
    step(1, 0, -1, 0, 1, 0, "R10 recover");
    step(0, 0, 2, 5'b00011, 0, 0, "R8 onehot two bits");
    step(1, 0, -1, 0, 1, 0, "R10 recover");
    step(0, 0, 2, 5'b11111, 0, 0, "R8 onehot all bits");
    step(0, 0, -1, 0, 1, 0, "R10 recover");
    step(0, 1, -1, 0, 1, 0, "R1 clear");
    step(1, 0, -1, 0, 1, 0, "R2 advance");
    step(0, 0, 2, 5'b01000, 1, 3, "R11 double flip undetected");
    step(1, 0, -1, 0, 1, 0, "R11 continues from new step");
    step(0, 1, 0, 4, 1, 4, "R12 load over clear");
    step(1, 0, 1, gcode(5), 1, 5, "R12 load over advance");
    step(1, 0, -1, 0, 1, 0, "R3 gray wrap");
    @(negedge clk); #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule